// File: doc/BRIEF.md
# Multi-Mode Logic Block Observer Register

This block is a parameterised-width register that takes the place of an ordinary pipeline register and adds self-test behaviour to it. A two-bit mode select and a pattern-generation enable choose what it does on each clock.

- **Capture:** it loads its parallel input word.
- **Clear:** it clears to zero on the clock.
- **Shift:** it acts as a serial shift chain, so test data can be moved in and out.
- **Compact:** it folds its parallel input word into a running signature through linear feedback.
- **Pattern generation:** when the enable is set while compacting, the parallel inputs are masked. The same feedback then runs on its own and produces a pseudorandom sequence for the logic downstream.

A register can therefore either generate patterns or compact responses in a given cycle, but never both. To test a pipeline, the registers around each logic stage are set to different roles in turn. In a first session the register in front of a stage generates patterns and the one after it compacts the responses. The resulting signature is then shifted out through the serial path.

The data interface is a plain register interface with no valid/ready handshake and no back-pressure. The register advances on every clock edge, and the parallel input is sampled at every edge in capture and compact modes.

Top module: `mlbo_reg`

## Requirements
- R1: While the active-low asynchronous reset `rst_n` is low, the register state `q` is all zeros and `so` is 0.
- R2: With `mode` = 2'b11 (capture), `q` takes the value of `d` on the next clock.
- R3: With `mode` = 2'b00 (clear), `q` becomes all zeros on the next clock, whatever `d`, `si` and `pg_en` are.
- R4: With `mode` = 2'b01 (shift), the next `q` is `{q[W-2:0], si}`: bit 0 loads from `si` and every other bit takes its lower neighbour. No feedback is applied.
- R5: With `mode` = 2'b10 and `pg_en` = 0 (compact), the next `q` is `{q[W-2:0], fb} ^ d`. Here `fb` is the XOR of the bits of `q` selected by the `TAPS` mask, which by default is 8'hB8 (bits 7, 5, 4 and 3).
- R6: With `mode` = 2'b10 and `pg_en` = 1 (pattern generation), `d` has no effect and the next `q` is `{q[W-2:0], fb}`.
- R7: In pattern generation, a `q` of all zeros is replaced on the next clock by the seed value 1 (only bit 0 set).
- R8: In pattern generation starting from a nonzero value, `q` never becomes zero. With the default taps, the sequence returns to its start after exactly 2^W-1 = 255 clocks.
- R9: `so` always equals the top bit `q[W-1]`, so after a session the signature leaves the register most significant bit first under shift mode.
- R10: In a chain of two registers with logic between them, the first register generating patterns and the second compacting the logic's outputs yields a signature in the second register that depends only on the seed and the logic. That signature can be shifted out serially.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 00 clear, 01 shift, 10 compact/generate, 11 capture |
| pg_en | input | 1 | In mode 10, masks `d` and turns on pattern generation |
| si | input | 1 | Serial input into bit 0 in shift mode |
| d | input | WIDTH | Parallel input word |
| q | output | WIDTH | Register state |
| so | output | 1 | Serial output, top bit of the state |

## Verification
The assertions check on every cycle that:

- clearing empties the register;
- capture tracks the input word;
- shifting moves each bit up by one and takes `si` into bit 0, and the previous next-to-top bit appears on `so`;
- pattern generation shifts the state up, seeds out of zero, and never falls back to zero.

Only the bench's scenarios can show:

- the exact signature values produced by the feedback taps;
- the 255-cycle period of the generator;
- that a masked `d` truly leaves no trace;
- the two-register session, in which one register's generated patterns pass through logic, are compacted in the other register, and are shifted out serially.

// File: rtl/mlbo_pkg.sv
package mlbo_pkg;

  typedef enum logic [1:0] {
    MD_CLEAR = 2'b00,
    MD_SHIFT = 2'b01,
    MD_SIG   = 2'b10,
    MD_LOAD  = 2'b11
  } mlbo_mode_e;

endpackage

// File: rtl/mlbo_parity.sv
// Feedback bit: XOR of the state bits selected by the tap mask, built as a chain.
module mlbo_parity #(
  parameter int unsigned         WIDTH = 8,
  parameter logic [WIDTH-1:0]    TAPS  = 8'hB8
) (
  input  logic [WIDTH-1:0] state_i,
  output logic             fb_o
);
  logic [WIDTH:0] chain;

  assign chain[0] = 1'b0;

  for (genvar g = 0; g < WIDTH; g++) begin : g_tap
    if (TAPS[g]) begin : g_on
      assign chain[g+1] = chain[g] ^ state_i[g];
    end else begin : g_off
      assign chain[g+1] = chain[g];
    end
  end

  assign fb_o = chain[WIDTH];
endmodule

// File: rtl/mlbo_next.sv
// Next-state selection shared by all modes.
module mlbo_next
  import mlbo_pkg::*;
#(
  parameter int unsigned      WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS  = 8'hB8
) (
  input  logic [1:0]       mode_i,
  input  logic             pg_en_i,
  input  logic             si_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] state_i,
  output logic [WIDTH-1:0] next_o
);
  localparam logic [WIDTH-1:0] SEED = {{(WIDTH-1){1'b0}}, 1'b1};

  logic             fb;
  logic [WIDTH-1:0] d_gated;
  logic [WIDTH-1:0] shifted_fb;
  logic [WIDTH-1:0] shifted_si;
  logic             state_zero;
  mlbo_mode_e       md;

  mlbo_parity #(.WIDTH(WIDTH), .TAPS(TAPS)) parity_i (
    .state_i (state_i),
    .fb_o    (fb)
  );

  // Parallel input is blocked bit by bit when generating patterns.
  for (genvar g = 0; g < WIDTH; g++) begin : g_mask
    assign d_gated[g] = d_i[g] & ~pg_en_i;
  end

  assign shifted_fb = {state_i[WIDTH-2:0], fb};
  assign shifted_si = {state_i[WIDTH-2:0], si_i};
  assign state_zero = (state_i == '0);
  assign md         = mlbo_mode_e'(mode_i);

  always_comb begin
    unique case (md)
      MD_CLEAR: next_o = '0;
      MD_SHIFT: next_o = shifted_si;
      MD_SIG: begin
        if (pg_en_i && state_zero) next_o = SEED;
        else                       next_o = shifted_fb ^ d_gated;
      end
      MD_LOAD:  next_o = d_i;
      default:  next_o = '0;
    endcase
  end
endmodule

// File: rtl/mlbo_reg.sv
// Multi-mode observer register: capture, clear, shift, compact, generate.
module mlbo_reg #(
  parameter int unsigned      WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS  = 8'hB8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             pg_en,
  input  logic             si,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             so
);
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;

  mlbo_next #(.WIDTH(WIDTH), .TAPS(TAPS)) next_i (
    .mode_i  (mode),
    .pg_en_i (pg_en),
    .si_i    (si),
    .d_i     (d),
    .state_i (state_q),
    .next_o  (state_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign q  = state_q;
  assign so = state_q[WIDTH-1];
endmodule

// File: rtl/mlbo_reg_chk.sv
module mlbo_reg_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             pg_en,
  input logic             si,
  input logic [WIDTH-1:0] d,
  input logic [WIDTH-1:0] q,
  input logic             so
);
  // R1
  reset_empty_chk: assert property (@(posedge clk) !rst_n |-> (q == '0 && so == 1'b0));

  // R2
  load_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b11 |=> q == $past(d));

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b00 |=> q == '0);

  // R4
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 |=> q == {$past(q[WIDTH-2:0]), $past(si)});

  // R9
  shift_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 |=> so == $past(q[WIDTH-2]));

  // R6
  gen_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && pg_en && q != '0) |=> q[WIDTH-1:1] == $past(q[WIDTH-2:0]));

  // R7
  gen_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && pg_en && q == '0) |=> q == {{(WIDTH-1){1'b0}}, 1'b1});

  // R8
  gen_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && pg_en && q != '0) |=> q != '0);
endmodule

bind mlbo_reg mlbo_reg_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode), .pg_en(pg_en),
  .si(si), .d(d), .q(q), .so(so)
);

// File: tb/mlbo_reg_tb_top.sv
module mlbo_reg_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic [1:0]   mode, mode_b;
  logic         pg_en, pg_b, si, si_b;
  logic [W-1:0] d, q, q_b, d_b;
  logic         so, so_b;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  mlbo_reg #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pg_en(pg_en),
    .si(si), .d(d), .q(q), .so(so));

  // Logic stage between the two registers of the pipeline session.
  function automatic logic [W-1:0] stage_fn(logic [W-1:0] x);
    return {x[3:0], x[7:4]} ^ 8'h5A;
  endfunction

  assign d_b = stage_fn(q);

  mlbo_reg #(.WIDTH(W)) stage_b_i (
    .clk(clk), .rst_n(rst_n), .mode(mode_b), .pg_en(pg_b),
    .si(si_b), .d(d_b), .q(q_b), .so(so_b));

  // Model written from the requirements (taps bits 7,5,4,3).
  function automatic logic [W-1:0] model(logic [W-1:0] s, logic [1:0] m,
                                          logic p, logic i, logic [W-1:0] x);
    logic fb;
    fb = s[7] ^ s[5] ^ s[4] ^ s[3];
    case (m)
      2'b00:   return '0;
      2'b01:   return {s[6:0], i};
      2'b10:   if (p) return (s == '0) ? 8'h01 : {s[6:0], fb};
               else   return {s[6:0], fb} ^ x;
      default: return x;
    endcase
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic [1:0] m, logic p, logic i, logic [W-1:0] x);
    @(negedge clk);
    mode = m; pg_en = p; si = i; d = x;
    @(posedge clk);
    #1;
  endtask

  typedef struct packed {
    logic [1:0]   md;
    logic         pg;
    logic         sin;
    logic [W-1:0] din;
    logic [W-1:0] qexp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'b11, 1'b0, 1'b0, 8'hA5, 8'hA5},  // R2 capture
    '{2'b01, 1'b0, 1'b1, 8'h00, 8'h4B},  // R4 shift in 1
    '{2'b01, 1'b0, 1'b0, 8'hFF, 8'h96},  // R4 shift in 0
    '{2'b00, 1'b1, 1'b1, 8'hFF, 8'h00},  // R3 clear
    '{2'b10, 1'b0, 1'b0, 8'h3C, 8'h3C},  // R5 compact from zero, no seed
    '{2'b10, 1'b0, 1'b0, 8'h00, 8'h79},  // R5 feedback = 1
    '{2'b10, 1'b1, 1'b0, 8'hFF, 8'hF3},  // R6 d masked
    '{2'b00, 1'b0, 1'b0, 8'h00, 8'h00},  // R3 clear
    '{2'b10, 1'b1, 1'b0, 8'h55, 8'h01},  // R7 seed out of zero
    '{2'b10, 1'b1, 1'b1, 8'hAA, 8'h02},  // R6 generate
    '{2'b11, 1'b0, 1'b0, 8'h00, 8'h00},  // R2 capture zero
    '{2'b10, 1'b0, 1'b0, 8'hFF, 8'hFF},  // R5 compact
    '{2'b10, 1'b0, 1'b0, 8'h01, 8'hFF}   // R5 feedback = 0
  };

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ma, mb, start;
    bit zero_seen;
    mode = 2'b11; pg_en = 0; si = 0; d = 8'hC3;
    mode_b = 2'b00; pg_b = 0; si_b = 0;
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset q", q, 8'h00);
    check("R1 reset so", {7'b0, so}, 8'h00);
    @(negedge clk); rst_n = 1;

    // Vector table.
    for (int k = 0; k < NV; k++) begin
      step(VECS[k].md, VECS[k].pg, VECS[k].sin, VECS[k].din);
      check($sformatf("R2-6 vec%0d", k), q, VECS[k].qexp);
      check($sformatf("R9 so vec%0d", k), {7'b0, so}, {7'b0, VECS[k].qexp[7]});
    end

    // R1: async reset mid-run, between edges.
    step(2'b11, 0, 0, 8'h7E);
    @(negedge clk); #2 rst_n = 0; #1;
    check("R1 async clear", q, 8'h00);
    @(negedge clk); rst_n = 1;

    // R8: period and never zero from seed 1.
    step(2'b11, 0, 0, 8'h01);
    start = q; zero_seen = 0;
    for (int k = 0; k < 255; k++) begin
      step(2'b10, 1, 0, 8'hFF);
      if (q == '0) zero_seen = 1;
      if (k < 254 && q == start) zero_seen = 1;
    end
    check("R8 never zero or early repeat", {7'b0, zero_seen}, 8'h00);
    check("R8 period 255", q, start);

    // R6: masked d leaves no trace; compare two runs with different d.
    step(2'b11, 0, 0, 8'h3A);
    step(2'b10, 1, 0, 8'h00);
    ma = q;
    step(2'b11, 0, 0, 8'h3A);
    step(2'b10, 1, 0, 8'hFF);
    check("R6 d ignored", q, ma);

    // Model-driven mixed sequence.
    ma = q;
    for (int k = 0; k < 40; k++) begin
      logic [1:0] m; logic p, i; logic [W-1:0] x;
      m = 2'((k * 7 + 3) % 4); p = k[1]; i = k[0] ^ k[2];
      x = 8'((k * 37) ^ 8'h69);
      ma = model(ma, m, p, i, x);
      step(m, p, i, x);
      check($sformatf("R5 mixed %0d", k), q, ma);
    end

    // R10: two-register session. dut_i generates, stage_b_i compacts.
    step(2'b00, 0, 0, 8'h00);
    @(negedge clk); mode_b = 2'b00;
    @(posedge clk); #1;
    ma = q; mb = q_b;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      mode = 2'b10; pg_en = 1; mode_b = 2'b10; pg_b = 0;
      mb = model(mb, 2'b10, 0, 0, stage_fn(ma));
      ma = model(ma, 2'b10, 1, 0, 8'h00);
      @(posedge clk); #1;
    end
    check("R10 generator state", q, ma);
    check("R10 signature", q_b, mb);
    // Shift signature out MSB first.
    @(negedge clk); mode = 2'b00; mode_b = 2'b01; si_b = 0;
    for (int k = 0; k < W; k++) begin
      check($sformatf("R10 R9 serial bit %0d", k), {7'b0, so_b}, {7'b0, mb[W-1-k]});
      @(posedge clk); #1;
      @(negedge clk);
    end
    check("R10 R4 chain empty", q_b, 8'h00);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule